// File: doc/BRIEF.md
# Programmable Pulse-Swallow Frequency Divider

This block produces the two comparison pulses that feed a phase detector in a frequency synthesizer. On the oscillator side it divides the oscillator clock by N = P*B + A. A dual-modulus prescaler counts either P or P+1 oscillator cycles per prescaler period. A swallow counter holds it at P+1 for the first A prescaler periods of each output period. A main counter ends the output period after B prescaler periods. A wide-modulus select picks P = 32 or P = 64.

On the reference side an independent counter divides the reference clock by R. Each side runs on its own clock and reset. Each side emits exactly one single-cycle pulse per completed division.

Divider settings are plain level inputs and are not registered on the fly. Each side samples its settings only at a division boundary. A host can therefore rewrite them at any moment without shortening or stretching the period in progress. There is no data stream at the edge of this block, so there is no valid/ready handshake: all pins are plain control and status.

Top module: `pswal_divider`

## Requirements
- R1: With `wide_mod` = 0 and `main_val` >= `swallow_val`, consecutive `osc_div_pulse` pulses are exactly 32*`main_val` + `swallow_val` oscillator cycles apart.
- R2: With `wide_mod` = 1 the prescaler modulus pair becomes 64/65, so the spacing is 64*`main_val` + `swallow_val` oscillator cycles.
- R3: `swallow_val` is 7 bits (0..127) and `main_val` is 11 bits. A `main_val` below 3 is used as 3.
- R4: When the effective `main_val` is smaller than `swallow_val`, every prescaler period of that division uses the P+1 modulus, so the spacing is (P+1)*`main_val`. `osc_cfg_err` is high for exactly the divisions that use such a setting and is 0 otherwise.
- R5: Consecutive `ref_div_pulse` pulses are `ref_val` reference cycles apart. `ref_val` is 15 bits, and values below 3 are used as 3.
- R6: Settings are sampled only at a division boundary on each side. A change during a division leaves that division's length unchanged, and the new setting governs the next full division.
- R7: Each output pulse lasts exactly one cycle of its own clock.
- R8: During reset both pulse outputs and `osc_cfg_err` are 0. The first clock edge after reset loads the settings, and the first pulse follows that edge by one full division (N or R cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock being divided |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator side |
| ref_clk | input | 1 | Reference clock being divided |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference side |
| wide_mod | input | 1 | Modulus select: 0 gives 32/33, 1 gives 64/65 |
| swallow_val | input | 7 | Swallow count A (prescaler periods at P+1) |
| main_val | input | 11 | Main count B (prescaler periods per output period) |
| ref_val | input | 15 | Reference division ratio R |
| osc_div_pulse | output | 1 | One-cycle pulse per completed oscillator division |
| ref_div_pulse | output | 1 | One-cycle pulse per completed reference division |
| osc_cfg_err | output | 1 | Active setting has swallow count above main count |

## Verification
On every cycle, the assertions check that each pulse is one cycle wide and that consecutive pulses are never closer than the shortest legal division. They also check that the error flag changes only together with an oscillator pulse, once the first load after reset is past. The exact ratios cannot be seen from a single cycle, so only the bench scenarios show them. These include the modulus pair, the clamping of small B and R, the all-P+1 behaviour when B < A, the boundary-only take-over of new settings, and the timing of the first pulse after reset.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

  localparam int unsigned SWAL_W   = 7;
  localparam int unsigned MAIN_W   = 11;
  localparam int unsigned REF_W    = 15;
  localparam int unsigned MOD_LO   = 32;
  localparam int unsigned MOD_HI   = 64;
  localparam int unsigned MAIN_MIN = 3;
  localparam int unsigned REF_MIN  = 3;

  // Raise a value to a floor; used for the bounded count ranges.
  function automatic logic [31:0] floor_at(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int unsigned MOD_LO = 32,
  parameter int unsigned MOD_HI = 64,
  localparam int unsigned PC_W  = $clog2(MOD_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wide,
  input  logic plus1,
  output logic tick
);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] limit;

  // Last count value of the current prescaler period: P-1 or P.
  always_comb begin
    base  = wide ? PC_W'(MOD_HI - 1) : PC_W'(MOD_LO - 1);
    limit = base + PC_W'(plus1);
  end

  assign tick = run && (pc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (!run || tick) begin
      pc <= '0;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

endmodule

// File: rtl/pswal_swallow_ctrl.sv
module pswal_swallow_ctrl #(
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned MAIN_W   = 11,
  parameter int unsigned MAIN_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide_in,
  input  logic [SWAL_W-1:0] swal_in,
  input  logic [MAIN_W-1:0] main_in,
  output logic              run,
  output logic              wide_act,
  output logic              plus1,
  output logic              div_pulse,
  output logic              cfg_err
);

  import pswal_pkg::floor_at;

  logic [SWAL_W-1:0] swal_rem;
  logic [MAIN_W-1:0] main_rem;
  logic [MAIN_W-1:0] main_eff;
  logic              loaded;
  logic              last_period;
  logic              swal_over;

  always_comb begin
    main_eff    = MAIN_W'(floor_at(32'(main_in), 32'(MAIN_MIN)));
    swal_over   = 32'(swal_in) > 32'(main_eff);
    last_period = (main_rem == MAIN_W'(1));
  end

  assign run   = loaded;
  assign plus1 = (swal_rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded    <= 1'b0;
      swal_rem  <= '0;
      main_rem  <= '0;
      wide_act  <= 1'b0;
      cfg_err   <= 1'b0;
      div_pulse <= 1'b0;
    end else if (!loaded || (tick && last_period)) begin
      // Division boundary (or first edge after reset): take new settings.
      loaded    <= 1'b1;
      swal_rem  <= swal_in;
      main_rem  <= main_eff;
      wide_act  <= wide_in;
      cfg_err   <= swal_over;
      div_pulse <= loaded;
    end else begin
      div_pulse <= 1'b0;
      if (tick) begin
        main_rem <= main_rem - MAIN_W'(1);
        if (plus1) begin
          swal_rem <= swal_rem - SWAL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pswal_ref_div.sv
module pswal_ref_div #(
  parameter int unsigned REF_W   = 15,
  parameter int unsigned REF_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ratio_in,
  output logic             div_pulse
);

  import pswal_pkg::floor_at;

  logic [REF_W-1:0] cnt;
  logic [REF_W-1:0] reload;
  logic             loaded;

  always_comb begin
    reload = REF_W'(floor_at(32'(ratio_in), 32'(REF_MIN))) - REF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded    <= 1'b0;
      cnt       <= '0;
      div_pulse <= 1'b0;
    end else if (!loaded || cnt == '0) begin
      loaded    <= 1'b1;
      cnt       <= reload;
      div_pulse <= loaded;
    end else begin
      cnt       <= cnt - REF_W'(1);
      div_pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider #(
  parameter int unsigned SWAL_W   = pswal_pkg::SWAL_W,
  parameter int unsigned MAIN_W   = pswal_pkg::MAIN_W,
  parameter int unsigned REF_W    = pswal_pkg::REF_W,
  parameter int unsigned MOD_LO   = pswal_pkg::MOD_LO,
  parameter int unsigned MOD_HI   = pswal_pkg::MOD_HI,
  parameter int unsigned MAIN_MIN = pswal_pkg::MAIN_MIN,
  parameter int unsigned REF_MIN  = pswal_pkg::REF_MIN
) (
  input  logic              osc_clk,
  input  logic              osc_rst_n,
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              wide_mod,
  input  logic [SWAL_W-1:0] swallow_val,
  input  logic [MAIN_W-1:0] main_val,
  input  logic [REF_W-1:0]  ref_val,
  output logic              osc_div_pulse,
  output logic              ref_div_pulse,
  output logic              osc_cfg_err
);

  logic pre_tick;
  logic pre_run;
  logic pre_wide;
  logic pre_plus1;

  pswal_prescaler #(
    .MOD_LO (MOD_LO),
    .MOD_HI (MOD_HI)
  ) u_pre (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .run   (pre_run),
    .wide  (pre_wide),
    .plus1 (pre_plus1),
    .tick  (pre_tick)
  );

  pswal_swallow_ctrl #(
    .SWAL_W   (SWAL_W),
    .MAIN_W   (MAIN_W),
    .MAIN_MIN (MAIN_MIN)
  ) u_ctrl (
    .clk       (osc_clk),
    .rst_n     (osc_rst_n),
    .tick      (pre_tick),
    .wide_in   (wide_mod),
    .swal_in   (swallow_val),
    .main_in   (main_val),
    .run       (pre_run),
    .wide_act  (pre_wide),
    .plus1     (pre_plus1),
    .div_pulse (osc_div_pulse),
    .cfg_err   (osc_cfg_err)
  );

  pswal_ref_div #(
    .REF_W   (REF_W),
    .REF_MIN (REF_MIN)
  ) u_ref (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .ratio_in  (ref_val),
    .div_pulse (ref_div_pulse)
  );

endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk #(
  parameter int unsigned MIN_OSC_GAP = pswal_pkg::MOD_LO * pswal_pkg::MAIN_MIN,
  parameter int unsigned MIN_REF_GAP = pswal_pkg::REF_MIN,
  parameter int unsigned GAP_W       = 20
) (
  input logic osc_clk,
  input logic osc_rst_n,
  input logic ref_clk,
  input logic ref_rst_n,
  input logic osc_div_pulse,
  input logic ref_div_pulse,
  input logic osc_cfg_err
);

  logic [GAP_W-1:0] osc_gap;
  logic [GAP_W-1:0] ref_gap;
  logic             osc_seen;
  logic             ref_seen;
  logic [1:0]       osc_prime;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      osc_gap   <= '0;
      osc_seen  <= 1'b0;
      osc_prime <= '0;
    end else begin
      osc_prime <= {osc_prime[0], 1'b1};
      if (osc_div_pulse) begin
        osc_gap  <= '0;
        osc_seen <= 1'b1;
      end else if (osc_gap != '1) begin
        osc_gap <= osc_gap + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ref_gap  <= '0;
      ref_seen <= 1'b0;
    end else if (ref_div_pulse) begin
      ref_gap  <= '0;
      ref_seen <= 1'b1;
    end else if (ref_gap != '1) begin
      ref_gap <= ref_gap + GAP_W'(1);
    end
  end

  AST_OSC_SINGLE_PULSE: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    osc_div_pulse |=> !osc_div_pulse); // R7

  AST_REF_SINGLE_PULSE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_div_pulse |=> !ref_div_pulse); // R7

  AST_OSC_MIN_SPACING: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (osc_seen && osc_div_pulse) |-> (osc_gap >= GAP_W'(MIN_OSC_GAP - 1))); // R3

  AST_REF_MIN_SPACING: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (ref_seen && ref_div_pulse) |-> (ref_gap >= GAP_W'(MIN_REF_GAP - 1))); // R5

  AST_ERR_AT_BOUNDARY: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (osc_prime[1] && !$stable(osc_cfg_err)) |-> osc_div_pulse); // R6

endmodule

bind pswal_divider pswal_divider_chk u_chk (
  .osc_clk       (osc_clk),
  .osc_rst_n     (osc_rst_n),
  .ref_clk       (ref_clk),
  .ref_rst_n     (ref_rst_n),
  .osc_div_pulse (osc_div_pulse),
  .ref_div_pulse (ref_div_pulse),
  .osc_cfg_err   (osc_cfg_err)
);

// File: tb/pswal_divider_bench.sv
module pswal_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 14;
  localparam int WATCHDOG   = 190000;

  typedef struct packed {
    logic        wide;
    logic [6:0]  sw;
    logic [10:0] mn;
    int          exp_n;
    logic        exp_err;
    int          tag;
  } ovec_t;

  localparam int NOV = 9;
  localparam ovec_t OVECS [NOV] = '{
    '{1'b0, 7'd0,   11'd3,   96,   1'b0, 1},
    '{1'b0, 7'd3,   11'd3,   99,   1'b0, 1},
    '{1'b0, 7'd5,   11'd7,   229,  1'b0, 1},
    '{1'b1, 7'd0,   11'd3,   192,  1'b0, 2},
    '{1'b1, 7'd10,  11'd12,  778,  1'b0, 2},
    '{1'b1, 7'd127, 11'd127, 8255, 1'b0, 3},
    '{1'b0, 7'd2,   11'd1,   98,   1'b0, 3},
    '{1'b0, 7'd6,   11'd4,   132,  1'b1, 4},
    '{1'b1, 7'd1,   11'd0,   193,  1'b0, 3}
  };

  localparam int NRV = 6;
  localparam logic [14:0] RVALS [NRV] = '{15'd3, 15'd1, 15'd100, 15'd32767, 15'd0, 15'd7};
  localparam int          REXPS [NRV] = '{3, 3, 100, 32767, 3, 7};

  logic        osc_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        osc_rst_n = 1'b0;
  logic        ref_rst_n = 1'b0;
  logic        wide_mod = 1'b0;
  logic [6:0]  swallow_val = '0;
  logic [10:0] main_val = '0;
  logic [14:0] ref_val = '0;
  logic        osc_div_pulse;
  logic        ref_div_pulse;
  logic        osc_cfg_err;

  int total = 0;
  int fails = 0;
  int osc_cyc = 0;
  int ref_cyc = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  always @(posedge osc_clk) osc_cyc <= osc_cyc + 1;
  always @(posedge ref_clk) ref_cyc <= ref_cyc + 1;

  pswal_divider u_pswal_divider (
    .osc_clk       (osc_clk),
    .osc_rst_n     (osc_rst_n),
    .ref_clk       (ref_clk),
    .ref_rst_n     (ref_rst_n),
    .wide_mod      (wide_mod),
    .swallow_val   (swallow_val),
    .main_val      (main_val),
    .ref_val       (ref_val),
    .osc_div_pulse (osc_div_pulse),
    .ref_div_pulse (ref_div_pulse),
    .osc_cfg_err   (osc_cfg_err)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic osc_wait(output int at);
    do @(negedge osc_clk); while (osc_div_pulse !== 1'b1);
    at = osc_cyc;
  endtask

  task automatic ref_wait(output int at);
    do @(negedge ref_clk); while (ref_div_pulse !== 1'b1);
    at = ref_cyc;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic osc_flow();
    int c0, a1, a2, last, prevn;
    wide_mod    = OVECS[0].wide;
    swallow_val = OVECS[0].sw;
    main_val    = OVECS[0].mn;
    repeat (3) @(negedge osc_clk);
    check("R8 osc pulse in reset", int'(osc_div_pulse), 0);
    check("R8 err in reset", int'(osc_cfg_err), 0);
    c0 = osc_cyc;
    osc_rst_n = 1'b1;
    osc_wait(a1);
    check("R8 first osc pulse", a1 - c0, 1 + OVECS[0].exp_n);
    @(negedge osc_clk);
    check("R7 osc pulse width", int'(osc_div_pulse), 0);
    last  = a1;
    prevn = OVECS[0].exp_n;
    for (int i = 0; i < NOV; i++) begin
      wide_mod    = OVECS[i].wide;
      swallow_val = OVECS[i].sw;
      main_val    = OVECS[i].mn;
      osc_wait(a1);
      check("R6 osc division in progress kept", a1 - last, prevn);
      check("R4 err flag", int'(osc_cfg_err), int'(OVECS[i].exp_err));
      osc_wait(a2);
      check(tag_name(OVECS[i].tag), a2 - a1, OVECS[i].exp_n);
      last  = a2;
      prevn = OVECS[i].exp_n;
    end
  endtask

  task automatic ref_flow();
    int c0, a1, a2, last, prevn;
    ref_val = RVALS[0];
    repeat (3) @(negedge ref_clk);
    check("R8 ref pulse in reset", int'(ref_div_pulse), 0);
    c0 = ref_cyc;
    ref_rst_n = 1'b1;
    ref_wait(a1);
    check("R8 first ref pulse", a1 - c0, 1 + REXPS[0]);
    @(negedge ref_clk);
    check("R7 ref pulse width", int'(ref_div_pulse), 0);
    last  = a1;
    prevn = REXPS[0];
    for (int i = 0; i < NRV; i++) begin
      ref_val = RVALS[i];
      ref_wait(a1);
      check("R6 ref division in progress kept", a1 - last, prevn);
      ref_wait(a2);
      check("R5 ref ratio", a2 - a1, REXPS[i]);
      last  = a2;
      prevn = REXPS[i];
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge osc_clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", osc_cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    fork
      osc_flow();
      ref_flow();
    join
    finish_run();
  end

endmodule